// File: doc/BRIEF.md
# Windowed Four-Bank Byte RAM

This block is a byte-wide RAM that answers on a processor bus with a 16-bit address. It claims one contiguous 8 KiB window of the address space, at A000h by default, and ignores every other address. Inside the window the storage is split into four banks of 2048 bytes each. A comparison on the top address bits decides whether the access belongs to the module. A 2-to-4 one-hot decoder on the next two bits then picks the bank, and the low eleven bits pick the byte inside that bank.

The bus side has a shared read strobe and a shared write strobe. Both strobes reach all banks, and only the bank picked by the decoder acts on them. A write is stored on the clock edge that samples it. A read returns its byte one cycle later, together with a flag that says whether the read landed inside the window. The window base is a parameter, so the same block can be placed at any 8 KiB boundary.

Top module: `banked_window_ram`

## Requirements
- R1: While reset is asserted, and in the first cycle after it, `rd_valid` is 0 and `rd_data` is 0.
- R2: An access is inside the window only when `addr[15:13]` equals the top three bits of the base parameter. For the default base A000h those bits are 3'b101, so the window is A000h..BFFFh.
- R3: Inside the window, `addr[12:11]` selects the bank. The values 0, 1, 2 and 3 select the ranges A000h–A7FFh, A800h–AFFFh, B000h–B7FFh and B800h–BFFFh. Each bank has its own storage, so the same offset in two banks holds two independent bytes.
- R4: `addr[10:0]` selects the byte inside the chosen bank, covering offsets 000h through 7FFh.
- R5: When `wr_en` is 1 and the address is inside the window, `wr_data` is stored on that rising clock edge.
- R6: A write to an address outside the window changes no stored byte in any bank.
- R7: A read with `rd_en` = 1 at a window address sets `rd_valid` to 1 and `rd_data` to the stored byte on the cycle after the strobe was sampled.
- R8: A read outside the window gives `rd_valid` = 0 and `rd_data` = 0 on the following cycle.
- R9: If a read and a write hit the same address on the same edge, the read returns the byte held before that write.
- R10: In a cycle where `rd_en` was 0, the next cycle shows `rd_valid` = 0 and `rd_data` = 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| addr | input | 16 | Bus address |
| wr_data | input | 8 | Byte to be written |
| rd_en | input | 1 | Read strobe |
| wr_en | input | 1 | Write strobe |
| rd_data | output | 8 | Registered read byte, 0 when no read hit |
| rd_valid | output | 1 | The read sampled on the previous edge hit the window |

## Verification
The bench writes different bytes to the same offset in all four banks. A decoder that ignored bit 11 or 12, or ordered the banks wrongly, would read back a neighbour's byte. The bench also writes to addresses such as 0800h, 2000h, 8000h and E000h, whose low bits alias into the banks; a window compare that was missing or wrongly weighted would overwrite bytes the bench later reads back. Other stimuli cover the first and last byte of each bank, a read and a write to the same address on one edge (which must return the old byte), and reads alternating between inside and outside the window. These catch a valid flag or data output that lingers for an extra cycle, or leaks data on a miss.

// File: rtl/bwr_pkg.sv
package bwr_pkg;
  // Default geometry of the module.
  localparam int unsigned BWR_ADDR_W  = 16;
  localparam int unsigned BWR_DATA_W  = 8;
  localparam int unsigned BWR_BANK_AW = 11;
  localparam int unsigned BWR_SEL_W   = 2;
  localparam logic [15:0] BWR_BASE    = 16'hA000;
endpackage

// File: rtl/bwr_rst_sync.sv
module bwr_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) chain_q <= '0;
    else        chain_q <= chain_d;
  end

  assign rst_sync_n = chain_q[STAGES-1];
endmodule

// File: rtl/bwr_addr_decode.sv
module bwr_addr_decode #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned BANK_AW = 11,
  parameter int unsigned SEL_W   = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hA000,
  localparam int unsigned MATCH_W = ADDR_W - BANK_AW - SEL_W,
  localparam int unsigned NBANK   = 1 << SEL_W
) (
  input  logic [ADDR_W-1:0]  addr,
  output logic               in_window,
  output logic [NBANK-1:0]   bank_sel,
  output logic [BANK_AW-1:0] word_addr
);
  localparam logic [MATCH_W-1:0] PATTERN = BASE_ADDR[ADDR_W-1 -: MATCH_W];

  logic [MATCH_W-1:0] top_bits;
  logic [SEL_W-1:0]   sel_bits;

  assign top_bits  = addr[ADDR_W-1 -: MATCH_W];
  assign sel_bits  = addr[BANK_AW +: SEL_W];
  assign word_addr = addr[BANK_AW-1:0];
  assign in_window = (top_bits == PATTERN);

  // The decoder is enabled by the window match; one output per bank.
  for (genvar g = 0; g < NBANK; g++) begin : g_dec
    assign bank_sel[g] = in_window && (sel_bits == SEL_W'(g));
  end
endmodule

// File: rtl/bwr_bank.sv
module bwr_bank #(
  parameter int unsigned AW = 11,
  parameter int unsigned DW = 8,
  localparam int unsigned DEPTH = 1 << AW
) (
  input  logic          clk,
  input  logic          we,
  input  logic          re,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] q
);
  logic [DW-1:0] store [DEPTH];

  // Storage carries no reset; contents are defined only after a write.
  always_ff @(posedge clk) begin
    if (we) store[addr] <= wdata;
  end

  // Read samples the old contents, so a same-edge write is not seen.
  always_ff @(posedge clk) begin
    if (re) q <= store[addr];
  end
endmodule

// File: rtl/banked_window_ram.sv
module banked_window_ram #(
  parameter int unsigned ADDR_W  = bwr_pkg::BWR_ADDR_W,
  parameter int unsigned DATA_W  = bwr_pkg::BWR_DATA_W,
  parameter int unsigned BANK_AW = bwr_pkg::BWR_BANK_AW,
  parameter int unsigned SEL_W   = bwr_pkg::BWR_SEL_W,
  parameter logic [ADDR_W-1:0] BASE_ADDR = bwr_pkg::BWR_BASE
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic              rd_en,
  input  logic              wr_en,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int unsigned NBANK = 1 << SEL_W;

  logic               core_rst_n;
  logic               in_window;
  logic [NBANK-1:0]   bank_sel;
  logic [BANK_AW-1:0] word_addr;
  logic [DATA_W-1:0]  bank_q [NBANK];

  logic [NBANK-1:0]   rsel_d, rsel_q;
  logic               valid_d, valid_q;
  logic [DATA_W-1:0]  mux_data;

  bwr_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (core_rst_n)
  );

  bwr_addr_decode #(
    .ADDR_W    (ADDR_W),
    .BANK_AW   (BANK_AW),
    .SEL_W     (SEL_W),
    .BASE_ADDR (BASE_ADDR)
  ) u_dec (
    .addr      (addr),
    .in_window (in_window),
    .bank_sel  (bank_sel),
    .word_addr (word_addr)
  );

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    bwr_bank #(.AW(BANK_AW), .DW(DATA_W)) u_bank (
      .clk   (clk),
      .we    (wr_en && bank_sel[b]),
      .re    (rd_en && bank_sel[b]),
      .addr  (word_addr),
      .wdata (wr_data),
      .q     (bank_q[b])
    );
  end

  // Next state of the read-return control.
  always_comb begin
    rsel_d  = rd_en ? bank_sel : '0;
    valid_d = rd_en && in_window;
  end

  always_ff @(posedge clk or negedge core_rst_n) begin
    if (!core_rst_n) begin
      rsel_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      rsel_q  <= rsel_d;
      valid_q <= valid_d;
    end
  end

  // Return mux: only the bank that was read drives data; a miss gives 0.
  always_comb begin
    mux_data = '0;
    for (int i = 0; i < NBANK; i++) begin
      if (rsel_q[i]) mux_data = mux_data | bank_q[i];
    end
  end

  assign rd_data  = mux_data;
  assign rd_valid = valid_q;
endmodule

// File: rtl/banked_window_ram_chk.sv
module banked_window_ram_chk #(
  parameter int unsigned ADDR_W  = 16,
  parameter int unsigned DATA_W  = 8,
  parameter int unsigned BANK_AW = 11,
  parameter int unsigned SEL_W   = 2,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 16'hA000
) (
  input logic              clk,
  input logic              rst_n,
  input logic              core_rst_n,
  input logic [ADDR_W-1:0] addr,
  input logic              rd_en,
  input logic [DATA_W-1:0] rd_data,
  input logic              rd_valid
);
  localparam int unsigned MATCH_W = ADDR_W - BANK_AW - SEL_W;
  localparam logic [MATCH_W-1:0] PATTERN = BASE_ADDR[ADDR_W-1 -: MATCH_W];

  logic hit_addr;
  assign hit_addr = (addr[ADDR_W-1 -: MATCH_W] == PATTERN);

  // R1
  reset_quiet_chk: assert property (@(posedge clk) !rst_n |-> (!rd_valid && rd_data == '0));

  // R2
  miss_no_valid_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_en && !hit_addr) |=> !rd_valid);

  // R7
  hit_valid_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    (rd_en && hit_addr) |=> rd_valid);

  // R8
  miss_zero_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !rd_valid |-> (rd_data == '0));

  // R10
  idle_chk: assert property (@(posedge clk) disable iff (!core_rst_n)
    !rd_en |=> !rd_valid);
endmodule

bind banked_window_ram banked_window_ram_chk #(
  .ADDR_W    (ADDR_W),
  .DATA_W    (DATA_W),
  .BANK_AW   (BANK_AW),
  .SEL_W     (SEL_W),
  .BASE_ADDR (BASE_ADDR)
) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .core_rst_n (core_rst_n),
  .addr       (addr),
  .rd_en      (rd_en),
  .rd_data    (rd_data),
  .rd_valid   (rd_valid)
);

// File: tb/banked_window_ram_tb_top.sv
module banked_window_ram_tb_top;
  logic        clk;
  logic        rst_n;
  logic [15:0] addr;
  logic [7:0]  wr_data;
  logic        rd_en;
  logic        wr_en;
  logic [7:0]  rd_data;
  logic        rd_valid;

  int checks;
  int errors;

  logic [7:0] model [int];
  logic       exp_valid;
  logic [7:0] exp_data;

  banked_window_ram dut_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .addr     (addr),
    .wr_data  (wr_data),
    .rd_en    (rd_en),
    .wr_en    (wr_en),
    .rd_data  (rd_data),
    .rd_valid (rd_valid)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  function automatic bit in_win(input logic [15:0] a);
    return (a >= 16'hA000) && (a <= 16'hBFFF);
  endfunction

  task automatic check(input string req, input logic [7:0] got_d, input logic got_v,
                       input logic [7:0] want_d, input logic want_v);
    checks++;
    if (got_v !== want_v || got_d !== want_d) begin
      errors++;
      $display("FAIL %s: got valid=%0b data=%02h, expected valid=%0b data=%02h",
               req, got_v, got_d, want_v, want_d);
    end
  endtask

  // One bus cycle: drive after the falling edge, update the model at the
  // rising edge, compare the registered outputs at the next falling edge.
  task automatic step(input string req, input logic [15:0] a, input logic [7:0] d,
                      input logic rd, input logic wr);
    addr = a; wr_data = d; rd_en = rd; wr_en = wr;
    @(posedge clk);
    exp_valid = rd && in_win(a);
    exp_data  = 8'h00;
    if (exp_valid) exp_data = model.exists(int'(a)) ? model[int'(a)] : 8'hxx;
    if (wr && in_win(a)) model[int'(a)] = d;
    @(negedge clk);
    check(req, rd_data, rd_valid, exp_data, exp_valid);
  endtask

  task automatic wr(input string req, input logic [15:0] a, input logic [7:0] d);
    step(req, a, d, 1'b0, 1'b1);
  endtask

  task automatic rd(input string req, input logic [15:0] a);
    step(req, a, 8'h00, 1'b1, 1'b0);
  endtask

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: got timeout, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    checks = 0; errors = 0;
    addr = '0; wr_data = '0; rd_en = 1'b0; wr_en = 1'b0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check("R1 in reset", rd_data, rd_valid, 8'h00, 1'b0);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R1 after release", rd_data, rd_valid, 8'h00, 1'b0);

    // R3: same offset, four banks, distinct bytes
    wr("R5 write bank0", 16'hA000, 8'h11);
    wr("R5 write bank1", 16'hA800, 8'h22);
    wr("R5 write bank2", 16'hB000, 8'h33);
    wr("R5 write bank3", 16'hB800, 8'h44);
    rd("R3 bank0", 16'hA000);
    rd("R3 bank1", 16'hA800);
    rd("R3 bank2", 16'hB000);
    rd("R3 bank3", 16'hB800);

    // R4: bank edges and mid offsets
    wr("R4 last bank0", 16'hA7FF, 8'h55);
    wr("R4 last bank3", 16'hBFFF, 8'h66);
    wr("R4 mid bank1",  16'hA923, 8'h77);
    rd("R4 last bank0", 16'hA7FF);
    rd("R4 last bank3", 16'hBFFF);
    rd("R4 mid bank1",  16'hA923);

    // R6: writes outside the window whose low bits alias the banks
    wr("R6 out 0000", 16'h0000, 8'hF0);
    wr("R6 out 0800", 16'h0800, 8'hF1);
    wr("R6 out 2000", 16'h2000, 8'hF2);
    wr("R6 out 8000", 16'h8000, 8'hF3);
    wr("R6 out C000", 16'hC000, 8'hF4);
    wr("R6 out E7FF", 16'hE7FF, 8'hF5);
    wr("R6 out 9800", 16'h9800, 8'hF6);
    rd("R6 bank0 kept", 16'hA000);
    rd("R6 bank1 kept", 16'hA800);
    rd("R6 bank0 top kept", 16'hA7FF);
    rd("R6 bank3 kept", 16'hB800);

    // R8 and R2: reads outside the window
    rd("R8 miss 2000", 16'h2000);
    rd("R2 miss 9FFF", 16'h9FFF);
    rd("R2 miss C000", 16'hC000);

    // R9: read and write to one address on one edge
    step("R9 same-edge rw", 16'hA000, 8'hAB, 1'b1, 1'b1);
    rd("R9 new value", 16'hA000);

    // R10: idle cycles drop valid
    step("R10 idle", 16'hB000, 8'h00, 1'b0, 1'b0);
    step("R10 write only", 16'hB001, 8'h5A, 1'b0, 1'b1);

    // R7: alternating hit/miss reads
    rd("R7 hit", 16'hB000);
    rd("R7 miss", 16'h3000);
    rd("R7 hit", 16'hB001);
    rd("R7 miss", 16'hFFFF);
    rd("R7 hit", 16'hBFFF);

    // R3/R4 sweep over many computed addresses
    for (int i = 0; i < 64; i++) begin
      logic [15:0] a;
      a = 16'hA000 + 16'(i * 131);
      wr("R5 sweep write", a, 8'(i * 7 + 3));
    end
    for (int i = 0; i < 64; i++) begin
      logic [15:0] a;
      a = 16'hA000 + 16'(i * 131);
      rd("R3 sweep read", a);
    end

    step("R10 final idle", 16'h0000, 8'h00, 1'b0, 1'b0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule